// File: doc/BRIEF.md
# Pipelined Synchronous Burst Static RAM Core

This block is a reduced-depth, synthesizable model of a synchronous burst static RAM with a two-stage read pipeline. Address, write controls and chip enables are all sampled on the rising clock edge. A burst of four words is generated internally: one of two address strobes loads a base address, and an advance input then steps a 2-bit counter. The counter runs either in linear or in interleaved order. A write stores either the whole 36-bit word or any mix of its four 9-bit lanes. Read data leaves through a registered output stage that is gated by an asynchronous output enable.

A single finite-state machine governs the chip. The state `ST_DESEL` means the chip is deselected and idle. The state `ST_BURST` means the chip is selected, and one access is made on every edge. The state `ST_SLEEP` means the chip is powered down and ignores every control. The transitions are:
- **load**: an accepted strobe with all three enables active, which moves to `ST_BURST`.
- **deselect**: an accepted strobe with an enable inactive, which moves to `ST_DESEL`.
- **continue**: `ST_BURST` with no strobe, which either advances the counter or holds the address.
- **doze**: the sleep input is high, which moves to `ST_SLEEP` from any state.
- **wake**: the sleep input is low while in `ST_SLEEP`, which moves to `ST_DESEL`.

Top module: `burst_sram_core`

## Requirements
- R1: After reset the chip is deselected. `rdata_drive_o` is 0 and `rdata_o` is all zeros.
- R2: When a load samples `order_linear`=1, the word address at burst step n (n=0..3) is the base address with its low two bits replaced by (base[1:0]+n) mod 4. The upper address bits stay fixed for the whole burst.
- R3: When a load samples `order_linear`=0, the low two bits at burst step n are base[1:0] XOR n.
- R4: When `wr_all_n`=0 on a write-capable access, all four lanes are written, regardless of `wr_byte_n` and `lane_en_n`. Lane i occupies bits [9i+8:9i].
- R5: When `wr_all_n`=1, lane i is written only if `wr_byte_n`=0 and `lane_en_n[i]`=0. Every other lane keeps its old contents. With `wr_byte_n`=1, nothing is written.
- R6: A read registered at edge k shows its data on `rdata_o`, with `rdata_drive_o`=1, after edge k+2. After edge k+1 that read is not yet visible.
- R7: While `en_a_n`=1, a low `load_p_n` is ignored. It neither loads, nor deselects, nor interrupts a running burst.
- R8: While `out_en_n`=1, `rdata_drive_o` is 0 and `rdata_o` is zero at once, without any clock edge. Lowering `out_en_n` restores the output within the same cycle.
- R9: While `sleep`=1 at an edge, no access is made and no write occurs, and the output stops driving. After `sleep` drops, the chip stays deselected until a new strobe arrives.
- R10: A strobe accepted while an enable is inactive deselects the chip. The output still shows the read from two edges earlier after that edge, and stops driving after the next edge.
- R11: An accepted `load_p_n` wins over `load_s_n`. `advance_n`=0 has no effect on an edge that carries an accepted strobe. `advance_n`=1 with no strobe repeats the current address.
- R12: An access started by `load_p_n` is always a read, and the write controls on that edge are ignored.
- R13: A load needs `en_a_n`=0, `en_b`=1 and `en_c_n`=0 together. A `load_s_n` strobe with any of these inactive writes nothing and leaves the chip deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Base word address, taken on a load |
| wdata_i | input | DATA_W | Write data, sampled on each write edge |
| rdata_o | output | DATA_W | Read data; zero when not driven |
| rdata_drive_o | output | 1 | High while `rdata_o` carries valid read data |
| load_p_n | input | 1 | Priority address strobe, active low, read-start only |
| load_s_n | input | 1 | Secondary address strobe, active low |
| advance_n | input | 1 | Step the burst counter, active low |
| wr_all_n | input | 1 | Full-word write, active low |
| wr_byte_n | input | 1 | Lane-write qualifier, active low |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| en_a_n | input | 1 | Chip enable, active low; also gates `load_p_n` |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| order_linear | input | 1 | 1 selects linear order, 0 selects interleaved order |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |

## Verification
The assertions assume that every input is a clean 0 or 1 at each rising edge. They also assume that `out_en_n` is the only input that changes between edges in a way that matters. The bench drives all controls at the falling edge and toggles `out_en_n` only inside one low clock phase. The data checks also assume that a location is read only after a write has filled it. The bench keeps a shadow copy of the array, and its directed scenarios read back only addresses they wrote earlier.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int unsigned CNT_W = 2;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_BURST = 2'd1,
        ST_SLEEP = 2'd2
    } chip_state_e;

    // Low address bits for burst step cnt from start, in either order.
    function automatic logic [CNT_W-1:0] burst_low(
        input logic [CNT_W-1:0] start,
        input logic [CNT_W-1:0] cnt,
        input logic             linear
    );
        return linear ? CNT_W'(start + cnt) : (start ^ cnt);
    endfunction

endpackage

// File: rtl/bsram_select_fsm.sv
module bsram_select_fsm
    import bsram_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep,
    input  logic        load_p_n,
    input  logic        load_s_n,
    input  logic        advance_n,
    input  logic        en_a_n,
    input  logic        en_b,
    input  logic        en_c_n,
    output chip_state_e state_q,
    output logic        load,
    output logic        step,
    output logic        acc_req,
    output logic        rd_only
);

    chip_state_e state_d;
    logic        sel_all;
    logic        p_hit;
    logic        s_hit;

    assign sel_all = ~en_a_n & en_b & ~en_c_n;
    // the priority strobe counts only while en_a_n is low
    assign p_hit   = ~load_p_n & ~en_a_n;
    assign s_hit   = ~load_s_n & ~p_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and per-edge commands
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        acc_req = 1'b0;
        rd_only = 1'b0;
        if (sleep) begin
            state_d = ST_SLEEP;
        end else if (p_hit) begin
            if (sel_all) begin
                state_d = ST_BURST;
                load    = 1'b1;
                acc_req = 1'b1;
                rd_only = 1'b1;
            end else begin
                state_d = ST_DESEL;
            end
        end else if (s_hit) begin
            if (sel_all) begin
                state_d = ST_BURST;
                load    = 1'b1;
                acc_req = 1'b1;
            end else begin
                state_d = ST_DESEL;
            end
        end else begin
            unique case (state_q)
                ST_BURST: begin
                    acc_req = 1'b1;
                    step    = ~advance_n;
                end
                ST_DESEL: state_d = ST_DESEL;
                ST_SLEEP: state_d = ST_DESEL;
                default:  state_d = ST_DESEL;
            endcase
        end
    end

    AST_BLOCKED_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && en_a_n && load_s_n && state_q != ST_SLEEP) |=> (state_q == $past(state_q))); // R7

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (state_q == ST_SLEEP)); // R9

endmodule

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              linear_in,
    output logic [ADDR_W-1:0] burst_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              lin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            lin_q  <= 1'b1;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
            lin_q  <= linear_in;
        end else if (step) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign burst_addr = {base_q[ADDR_W-1:CNT_W],
                         burst_low(base_q[CNT_W-1:0], cnt_q, lin_q)};

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(burst_addr[ADDR_W-1:CNT_W])); // R2

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(burst_addr)); // R11

endmodule

// File: rtl/bsram_lane_mask.sv
module bsram_lane_mask #(
    parameter int unsigned LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_en_n,
    input  logic             rd_only,
    output logic [LANES-1:0] lanes
);

    // full-word write overrides the per-lane enables
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lanes[l] = ~rd_only & (~wr_all_n | (~wr_byte_n & ~lane_en_n[l]));
    end

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 36,
    parameter int unsigned LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_v,
    input  logic [LANES-1:0]  lanes,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              is_write;

    assign is_write = |lanes;

    // late write: the access registered last edge commits on this edge
    always_ff @(posedge clk) begin
        if (acc_v && is_write) begin
            for (int l = 0; l < LANES; l++) begin
                if (lanes[l]) begin
                    mem[addr][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // first read stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_v & ~is_write;
            rd_data  <= mem[addr];
        end
    end

    AST_STAGE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_v)); // R6

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 36,
    parameter int unsigned LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_drive_o,
    input  logic              load_p_n,
    input  logic              load_s_n,
    input  logic              advance_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              order_linear,
    input  logic              out_en_n,
    input  logic              sleep
);

    chip_state_e       state_q;
    logic              load;
    logic              step;
    logic              acc_req;
    logic              rd_only;
    logic [ADDR_W-1:0] burst_addr;
    logic [LANES-1:0]  lanes_d;
    logic [LANES-1:0]  lanes_q;
    logic              acc_v_q;
    logic [DATA_W-1:0] din_q;
    logic [DATA_W-1:0] stage1_data;
    logic              stage1_v;
    logic              drv_q;
    logic              out_v_q;
    logic [DATA_W-1:0] out_q;

    bsram_select_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .load_p_n  (load_p_n),
        .load_s_n  (load_s_n),
        .advance_n (advance_n),
        .en_a_n    (en_a_n),
        .en_b      (en_b),
        .en_c_n    (en_c_n),
        .state_q   (state_q),
        .load      (load),
        .step      (step),
        .acc_req   (acc_req),
        .rd_only   (rd_only)
    );

    bsram_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .addr_in    (addr_i),
        .linear_in  (order_linear),
        .burst_addr (burst_addr)
    );

    bsram_lane_mask #(.LANES(LANES)) u_mask (
        .wr_all_n  (wr_all_n),
        .wr_byte_n (wr_byte_n),
        .lane_en_n (lane_en_n),
        .rd_only   (rd_only),
        .lanes     (lanes_d)
    );

    bsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_v    (acc_v_q),
        .lanes    (lanes_q),
        .din      (din_q),
        .addr     (burst_addr),
        .rd_data  (stage1_data),
        .rd_valid (stage1_v)
    );

    // access register, drive-enable register and second read stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_v_q <= 1'b0;
            lanes_q <= '0;
            din_q   <= '0;
            drv_q   <= 1'b0;
            out_v_q <= 1'b0;
            out_q   <= '0;
        end else begin
            acc_v_q <= acc_req;
            lanes_q <= acc_req ? lanes_d : '0;
            din_q   <= wdata_i;
            drv_q   <= (state_q == ST_BURST);
            out_v_q <= stage1_v;
            out_q   <= stage1_data;
        end
    end

    // output enable acts without a clock
    assign rdata_drive_o = out_v_q & drv_q & ~out_en_n;
    assign rdata_o       = rdata_drive_o ? out_q : '0;

    AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !rd_only && !wr_all_n) |=> (lanes_q == '1)); // R4

    AST_PRIO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rd_only) |=> (lanes_q == '0)); // R12

    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (!rdata_drive_o && rdata_o == '0)); // R8

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BURST) |=> !rdata_drive_o); // R10

    AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !acc_v_q); // R9

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_drive_o |-> $past(acc_v_q, 2)); // R6

endmodule

// File: tb/test_burst_sram_core.sv
module test_burst_sram_core;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  addr_i;
    logic [35:0] wdata_i;
    logic [35:0] rdata_o;
    logic        rdata_drive_o;
    logic        load_p_n, load_s_n, advance_n, wr_all_n, wr_byte_n;
    logic [3:0]  lane_en_n;
    logic        en_a_n, en_b, en_c_n, order_linear, out_en_n, sleep;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [35:0] shadow [64];

    always #2 clk = ~clk;

    burst_sram_core i_burst_sram_core (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .rdata_drive_o(rdata_drive_o),
        .load_p_n(load_p_n), .load_s_n(load_s_n), .advance_n(advance_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_en_n(lane_en_n),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .order_linear(order_linear), .out_en_n(out_en_n), .sleep(sleep)
    );

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_addr(input logic [5:0] base, input int n, input logic lin);
        logic [1:0] c = n[1:0];
        return {base[5:2], lin ? 2'(base[1:0] + c) : (base[1:0] ^ c)};
    endfunction

    task automatic idle();
        load_p_n = 1; load_s_n = 1; advance_n = 1; wr_all_n = 1; wr_byte_n = 1;
        lane_en_n = 4'hF; en_a_n = 0; en_b = 1; en_c_n = 0; out_en_n = 0; sleep = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic deselect();
        idle(); load_s_n = 0; en_b = 0; tick();
        idle(); tick(); tick();
    endtask

    task automatic wr_burst(input logic [5:0] base, input logic lin, input logic [35:0] d [4]);
        idle(); addr_i = base; order_linear = lin; load_s_n = 0; wr_all_n = 0; wdata_i = d[0];
        tick();
        for (int i = 1; i < 4; i++) begin
            load_s_n = 1; advance_n = 0; wdata_i = d[i];
            tick();
        end
        for (int i = 0; i < 4; i++) shadow[exp_addr(base, i, lin)] = d[i];
        deselect();
    endtask

    task automatic rd_burst(input string tag, input logic [5:0] base, input logic lin);
        idle(); addr_i = base; order_linear = lin; load_p_n = 0; advance_n = 0; // R11 advance ignored on load
        tick();
        for (int i = 1; i <= 5; i++) begin
            idle(); advance_n = (i <= 3) ? 1'b0 : 1'b1;
            tick();
            if (i == 1) check("R6 not yet driven", 36'(rdata_drive_o), 36'd0);
            else begin
                check("R6 driven", 36'(rdata_drive_o), 36'd1);
                check(tag, rdata_o, shadow[exp_addr(base, i - 2, lin)]);
            end
        end
        deselect();
    endtask

    task automatic rd_single(input string tag, input logic [5:0] a);
        idle(); addr_i = a; order_linear = 1; load_p_n = 0;
        tick();
        idle(); tick();
        check("R6 edge k+1", 36'(rdata_drive_o), 36'd0);
        tick();
        check("R6 edge k+2", 36'(rdata_drive_o), 36'd1);
        check(tag, rdata_o, shadow[a]);
        deselect();
    endtask

    task automatic wr_single(input logic [5:0] a, input logic [35:0] d,
                             input logic all_n, input logic byte_n, input logic [3:0] ln);
        idle(); addr_i = a; load_s_n = 0; wr_all_n = all_n; wr_byte_n = byte_n;
        lane_en_n = ln; wdata_i = d;
        tick();
        for (int l = 0; l < 4; l++)
            if (!all_n || (!byte_n && !ln[l])) shadow[a][l*9 +: 9] = d[l*9 +: 9];
        deselect();
    endtask

    task automatic t_reset();
        check("R1 drive after reset", 36'(rdata_drive_o), 36'd0);
        check("R1 data after reset", rdata_o, 36'd0);
    endtask

    task automatic t_linear();
        logic [35:0] d [4] = '{36'h1_0000_000A, 36'h2_0000_000B, 36'h3_0000_0008, 36'h4_0000_0009};
        wr_burst(6'h0A, 1'b1, d);
        rd_burst("R2 linear order", 6'h0A, 1'b1);
        rd_single("R2 linear placement", 6'h08);
    endtask

    task automatic t_interleaved();
        logic [35:0] d [4] = '{36'h5_1313_1313, 36'h6_1212_1212, 36'h7_1111_1111, 36'h8_1010_1010};
        wr_burst(6'h13, 1'b0, d);
        rd_burst("R3 interleaved order", 6'h13, 1'b0);
        rd_single("R3 interleaved placement", 6'h11);
    endtask

    task automatic t_lanes();
        wr_single(6'h20, 36'h1_2345_6789, 1'b0, 1'b1, 4'hF);
        rd_single("R4 full write", 6'h20);
        wr_single(6'h20, 36'hE_DCBA_9876, 1'b1, 1'b0, 4'b1010);
        rd_single("R5 lanes 0 and 2", 6'h20);
        wr_single(6'h20, 36'h0_0000_0000, 1'b1, 1'b1, 4'h0);
        rd_single("R5 no qualifier", 6'h20);
        wr_single(6'h20, 36'hA_5A5A_5A5A, 1'b0, 1'b1, 4'hF);
        rd_single("R4 overrides lanes", 6'h20);
    endtask

    task automatic t_blocked();
        idle(); addr_i = 6'h20; load_p_n = 0; tick();
        idle(); en_a_n = 1; load_p_n = 0; addr_i = 6'h0A; tick();
        idle(); tick();
        check("R7 first word", rdata_o, shadow[6'h20]);
        tick();
        check("R7 still driven", 36'(rdata_drive_o), 36'd1);
        check("R7 strobe ignored", rdata_o, shadow[6'h20]);
        out_en_n = 1; #0.5;
        check("R8 drive off", 36'(rdata_drive_o), 36'd0);
        check("R8 data zero", rdata_o, 36'd0);
        out_en_n = 0; #0.5;
        check("R8 drive back", 36'(rdata_drive_o), 36'd1);
        check("R8 data back", rdata_o, shadow[6'h20]);
        deselect();
    endtask

    task automatic t_deselect();
        idle(); addr_i = 6'h0A; load_p_n = 0; tick();
        idle(); tick(); tick();
        check("R10 driving before", 36'(rdata_drive_o), 36'd1);
        load_s_n = 0; en_b = 0; tick();
        check("R10 still driven one edge", 36'(rdata_drive_o), 36'd1);
        check("R10 data", rdata_o, shadow[6'h0A]);
        idle(); tick();
        check("R10 released", 36'(rdata_drive_o), 36'd0);
        tick();
    endtask

    task automatic t_sleep();
        idle(); sleep = 1; addr_i = 6'h0A; load_s_n = 0; wr_all_n = 0; wdata_i = 36'hA_AAAA_AAAA;
        tick(); tick(); tick();
        check("R9 asleep", 36'(rdata_drive_o), 36'd0);
        idle(); tick(); tick(); tick();
        check("R9 woke deselected", 36'(rdata_drive_o), 36'd0);
        rd_single("R9 no write while asleep", 6'h0A);
    endtask

    task automatic t_priority();
        idle(); addr_i = 6'h0B; load_p_n = 0; load_s_n = 0; wr_all_n = 0; wdata_i = 36'h0;
        tick();
        idle(); tick(); tick();
        check("R12 read on priority start", rdata_o, shadow[6'h0B]);
        deselect();
        rd_single("R11 priority strobe wins", 6'h0B);
    endtask

    task automatic t_enables();
        idle(); en_c_n = 1; addr_i = 6'h0A; load_s_n = 0; wr_all_n = 0; wdata_i = '1;
        tick(); idle(); tick(); tick();
        check("R13 en_c inactive", 36'(rdata_drive_o), 36'd0);
        idle(); en_b = 0; addr_i = 6'h0A; load_s_n = 0; wr_all_n = 0; wdata_i = '1;
        tick(); idle(); tick(); tick();
        check("R13 en_b inactive", 36'(rdata_drive_o), 36'd0);
        rd_single("R13 no write", 6'h0A);
    endtask

    initial begin
        rst_n = 0; idle(); addr_i = '0; wdata_i = '0; order_linear = 1;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_linear();
        t_interleaved();
        t_lanes();
        t_blocked();
        t_deselect();
        t_sleep();
        t_priority();
        t_enables();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule